// File: doc/BRIEF.md
# Delta-Sigma Decimator with Fast-Settling Startup

This block turns a 1-bit delta-sigma modulator stream into signed multi-bit conversion words. Each modulator bit is worth +1 when high and -1 when low. Two filter paths take the same bits in the same clock. The first is a boxcar (sinc1) accumulator that is cleared at every data period. The second is a third-order cascaded integrator-comb (sinc3) decimator. One data period is `OSR` modulator clocks.

A sequencer with three named states controls startup. `ST_POR` holds the active-low strobe low for the power-on settling time. The transition POR_DONE then raises the strobe and enters `ST_WAIT`. `ST_WAIT` discards modulator bits for `WAIT_CYC` clocks, with both filters held clear. The transition WAIT_DONE enters `ST_RUN`, where both paths accumulate. The transition SOFT_RESTART takes the block from `ST_WAIT` or `ST_RUN` back to `ST_WAIT`. It fires when the synchronous restart input is high, and it skips the power-on time.

The first two words after each startup come from the fast path, which settles within one period. Every later word comes from the sinc3 path, which needs three periods to settle. Both paths are scaled to the same full scale, so a steady input shows no step at the switchover.

Top module: `dsd_decim`

## Requirements
- R1: While `rst_n` is low, `drdy_n` is 0, `data_out` is 0 and `from_fast` is 0.
- R2: `drdy_n` rises exactly `POR_CYC` clock edges after `rst_n` is released. A `soft_rst` pulse during this interval has no effect on that timing.
- R3: On entering `ST_WAIT`, the next `WAIT_CYC` modulator bits are discarded. The first falling edge of `drdy_n` comes `WAIT_CYC + OSR` clock edges after the edge that entered `ST_WAIT`. Until then, `drdy_n` stays high.
- R4: In `ST_RUN`, `drdy_n` falls once every `OSR` clocks. It stays low for `DRDY_LOW` clocks and then returns high.
- R5: Words 1 and 2 after a startup equal the sum over that period of (+1 for bit 1, -1 for bit 0). This sum is multiplied by 2^(OUT_W-2-log2 OSR).
- R6: Words 3 onward equal the third-order boxcar convolution (window `OSR`, zero history before the first kept bit), sampled at the last bit of the period. This value is scaled by 2^(OUT_W-2-3·log2 OSR). A negative exponent is an arithmetic right shift.
- R7: `from_fast` is 1 with words 1 and 2 and 0 with later words. `data_out` and `from_fast` change only at a falling edge of `drdy_n`.
- R8: `soft_rst` high in `ST_WAIT` or `ST_RUN` forces `drdy_n` high at the next edge. The sequence then restarts at `ST_WAIT`, with no power-on interval.
- R9: A bit pattern with the same number of ones in every period gives the same `data_out` value for words 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous restart request, active high |
| mod_bit | input | 1 | Modulator bitstream |
| drdy_n | output | 1 | Active-low data-ready strobe |
| data_out | output | OUT_W | Signed conversion word |
| from_fast | output | 1 | High when the current word came from the fast path |

## Verification
The hardest case to reach from the ports is the third word. It is the only place where the path switch shows. It is also the only point where the sinc3 window starts two bits into the kept data, so an off-by-one in the integrator clearing or the wait length changes it. A bench with only steady input hides both kinds of error, because the two paths agree on steady data. The stimulus therefore uses a small `OSR`. It sweeps every possible ones-count, and it adds patterns whose density changes from period to period and pseudo-random streams. Garbage bits are driven during the wait. Each case is started by a restart that lands while the strobe is still low.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } dsd_state_e;
endpackage

// File: rtl/dsd_seq.sv
module dsd_seq
    import dsd_pkg::*;
#(
    parameter int OSR      = 1024,
    parameter int WAIT_CYC = 300,
    parameter int POR_CYC  = 64,
    parameter int DRDY_LOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    output logic run,
    output logic period_end,
    output logic use_fast,
    output logic drdy_n
);
    localparam int MAX_A = (POR_CYC > WAIT_CYC) ? POR_CYC : WAIT_CYC;
    localparam int CMAX  = (MAX_A > OSR) ? MAX_A : OSR;
    localparam int CNT_W = $clog2(CMAX + 1);
    localparam int LOW_W = $clog2(DRDY_LOW + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] PER_LAST  = CNT_W'(OSR - 1);

    dsd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       nsmp_q;
    logic [LOW_W-1:0] low_q;
    logic             drdy_q;
    logic             restart;

    assign run        = (state_q == ST_RUN);
    assign period_end = run && (cnt_q == PER_LAST) && !soft_rst;
    assign use_fast   = (nsmp_q != 2'd2);
    assign drdy_n     = drdy_q;
    assign restart    = (state_d != state_q) || (soft_rst && state_q != ST_POR);

    // Transitions: POR_DONE, WAIT_DONE, SOFT_RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR:  if (cnt_q == POR_LAST) state_d = ST_WAIT;
            ST_WAIT: if (!soft_rst && cnt_q == WAIT_LAST) state_d = ST_RUN;
            ST_RUN:  if (soft_rst) state_d = ST_WAIT;
            default: state_d = ST_POR;
        endcase
    end

    // State register with its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR;
            cnt_q   <= '0;
            nsmp_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            if (restart || period_end) cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
            if (restart)                              nsmp_q <= 2'd0;
            else if (period_end && nsmp_q != 2'd2)    nsmp_q <= nsmp_q + 2'd1;
        end
    end

    // Strobe output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
            low_q  <= '0;
        end else if (state_q == ST_POR) begin
            drdy_q <= (state_d == ST_WAIT);
        end else if (soft_rst) begin
            drdy_q <= 1'b1;
            low_q  <= '0;
        end else if (period_end) begin
            drdy_q <= 1'b0;
            low_q  <= LOW_W'(DRDY_LOW - 1);
        end else if (!drdy_q) begin
            if (low_q == '0) drdy_q <= 1'b1;
            else             low_q  <= low_q - 1'b1;
        end
    end

    p_soft_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && state_q != ST_POR) |=> (state_q == ST_WAIT && drdy_n));

    p_wait_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> drdy_n);

    p_fast_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_WAIT) |-> use_fast);
endmodule

// File: rtl/dsd_box.sv
module dsd_box #(
    parameter int OSR = 1024,
    localparam int AW = $clog2(OSR) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 last,
    input  logic                 mod_bit,
    output logic signed [AW-1:0] sum_o
);
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] step;

    always_comb step = mod_bit ? {{(AW-1){1'b0}}, 1'b1} : {AW{1'b1}};
    assign sum_o = acc_q + step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             acc_q <= '0;
        else if (!run || last)  acc_q <= '0;
        else                    acc_q <= sum_o;
    end

    p_box_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ($signed(acc_q) <= OSR && $signed(acc_q) >= -OSR));
endmodule

// File: rtl/dsd_cic3.sv
module dsd_cic3 #(
    parameter int OSR = 1024,
    localparam int W  = 3 * $clog2(OSR) + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                last,
    input  logic                mod_bit,
    output logic signed [W-1:0] y_o
);
    logic signed [W-1:0] i1_q, i2_q, i3_q;
    logic signed [W-1:0] d1_q, d2_q, d3_q;
    logic signed [W-1:0] n1, n2, n3, c1, c2, step;

    always_comb begin
        step = mod_bit ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};
        n1   = i1_q + step;
        n2   = i2_q + n1;
        n3   = i3_q + n2;
        c1   = n3 - d1_q;
        c2   = c1 - d2_q;
        y_o  = c2 - d3_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {i1_q, i2_q, i3_q} <= '0;
            {d1_q, d2_q, d3_q} <= '0;
        end else if (!run) begin
            {i1_q, i2_q, i3_q} <= '0;
            {d1_q, d2_q, d3_q} <= '0;
        end else begin
            i1_q <= n1;
            i2_q <= n2;
            i3_q <= n3;
            if (last) begin
                d1_q <= n3;
                d2_q <= c1;
                d3_q <= c2;
            end
        end
    end
endmodule

// File: rtl/dsd_decim.sv
module dsd_decim #(
    parameter int OSR      = 1024,
    parameter int WAIT_CYC = 300,
    parameter int POR_CYC  = 64,
    parameter int DRDY_LOW = 8,
    parameter int OUT_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             mod_bit,
    output logic             drdy_n,
    output logic [OUT_W-1:0] data_out,
    output logic             from_fast
);
    localparam int LG  = $clog2(OSR);
    localparam int SW1 = LG + 2;
    localparam int SW3 = 3 * LG + 2;
    localparam int SH1 = OUT_W - 2 - LG;

    logic run, period_end, use_fast;
    logic signed [SW1-1:0] s1;
    logic signed [SW3-1:0] s3;
    logic signed [OUT_W-1:0] fast_w, slow_w;

    dsd_seq #(.OSR(OSR), .WAIT_CYC(WAIT_CYC), .POR_CYC(POR_CYC), .DRDY_LOW(DRDY_LOW)) i_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .period_end(period_end), .use_fast(use_fast), .drdy_n(drdy_n)
    );

    dsd_box #(.OSR(OSR)) i_box (
        .clk(clk), .rst_n(rst_n), .run(run), .last(period_end),
        .mod_bit(mod_bit), .sum_o(s1)
    );

    dsd_cic3 #(.OSR(OSR)) i_cic (
        .clk(clk), .rst_n(rst_n), .run(run), .last(period_end),
        .mod_bit(mod_bit), .y_o(s3)
    );

    logic signed [OUT_W+SW1-1:0] f_ext, f_sh;
    assign f_ext  = {{OUT_W{s1[SW1-1]}}, s1};
    assign f_sh   = f_ext <<< SH1;
    assign fast_w = f_sh[OUT_W-1:0];

    logic signed [OUT_W+SW3-1:0] s_ext, s_sh;
    assign s_ext = {{OUT_W{s3[SW3-1]}}, s3};
    generate
        if (3 * LG >= OUT_W - 2) begin : g_shr
            localparam int SHR = 3 * LG - (OUT_W - 2);
            assign s_sh = s_ext >>> SHR;
        end else begin : g_shl
            localparam int SHL = (OUT_W - 2) - 3 * LG;
            assign s_sh = s_ext <<< SHL;
        end
    endgenerate
    assign slow_w = s_sh[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out  <= '0;
            from_fast <= 1'b0;
        end else if (period_end) begin
            data_out  <= use_fast ? fast_w : slow_w;
            from_fast <= use_fast;
        end
    end

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_end) |-> ($stable(data_out) && $stable(from_fast)));

    p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(period_end));
endmodule

// File: tb/test_dsd_decim.sv
`timescale 1ns/1ps
module test_dsd_decim;
    localparam int OSR   = 16;
    localparam int LG    = 4;
    localparam int WAITC = 300;
    localparam int PORC  = 40;
    localparam int LOWC  = 4;
    localparam int OW    = 24;
    localparam int NS    = 4;
    localparam int NX    = NS * OSR;

    logic clk = 1'b0;
    logic rst_n = 1'b0, soft_rst = 1'b0, mod_bit = 1'b0;
    logic drdy_n, from_fast;
    logic [OW-1:0] data_out;
    int n_run = 0, n_fail = 0;
    bit xb [NX];

    always #2 clk = ~clk;

    dsd_decim #(.OSR(OSR), .WAIT_CYC(WAITC), .POR_CYC(PORC), .DRDY_LOW(LOWC), .OUT_W(OW)) i_dsd_decim (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mod_bit(mod_bit),
        .drdy_n(drdy_n), .data_out(data_out), .from_fast(from_fast)
    );

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // Positioned at the negedge just after the edge that entered the wait state.
    task automatic run_seq(input bit garb, input bit dc);
        longint c1 [NX], c2 [NX], c3 [NX];
        longint expd [NS+1];
        longint fsum, got;
        int dr_bad = 0, hold_bad = 0, p;
        logic [OW-1:0] last_d = '0;
        bit pre_hi = 1'b0, at_lo = 1'b0, exp_dr;
        for (int m = 0; m < NX; m++) begin
            c1[m] = 0;
            for (int j = m - OSR + 1; j <= m; j++) if (j >= 0) c1[m] += xb[j] ? 1 : -1;
        end
        for (int m = 0; m < NX; m++) begin
            c2[m] = 0;
            for (int j = m - OSR + 1; j <= m; j++) if (j >= 0) c2[m] += c1[j];
        end
        for (int m = 0; m < NX; m++) begin
            c3[m] = 0;
            for (int j = m - OSR + 1; j <= m; j++) if (j >= 0) c3[m] += c2[j];
        end
        for (int q = 1; q <= NS; q++) begin
            fsum = 0;
            for (int j = (q - 1) * OSR; j < q * OSR; j++) fsum += xb[j] ? 1 : -1;
            expd[q] = (q <= 2) ? fsum * (64'sd1 <<< (OW - 2 - LG))
                               : c3[q * OSR - 1] * (64'sd1 <<< (OW - 2 - 3 * LG));
        end
        expd[0] = 0;
        for (int j = 0; j <= WAITC + NS * OSR; j++) begin
            if (j < WAITC + OSR) exp_dr = 1'b1;
            else exp_dr = (((j - WAITC - OSR) % OSR) < LOWC) ? 1'b0 : 1'b1;
            if (drdy_n !== exp_dr) dr_bad++;
            if (j == WAITC + OSR - 1) pre_hi = (drdy_n === 1'b1);
            if (j == WAITC + OSR)     at_lo  = (drdy_n === 1'b0);
            if (j >= WAITC + OSR && ((j - WAITC) % OSR) == 0) begin
                p = (j - WAITC) / OSR;
                got = longint'($signed(data_out));
                if (p <= 2) chk(got == expd[p], "R5 fast word", got, expd[p]);
                else        chk(got == expd[p], "R6 sinc3 word", got, expd[p]);
                chk(from_fast == (p <= 2), "R7 path flag", longint'(from_fast), longint'(p <= 2));
            end else if (j > 0 && data_out !== last_d) hold_bad++;
            last_d = data_out;
            soft_rst = 1'b0;
            mod_bit = (j < WAITC) ? garb : xb[(j - WAITC) % NX];
            @(negedge clk);
        end
        chk(pre_hi && at_lo, "R3 first strobe position", longint'(at_lo), 1);
        chk(dr_bad == 0, "R4 R8 strobe pattern mismatches", dr_bad, 0);
        chk(hold_bad == 0, "R7 word hold mismatches", hold_bad, 0);
        if (dc) chk(expd[1] == expd[2] && expd[2] == expd[3] && expd[3] == expd[4],
                    "R9 steady words bench model", expd[3], expd[1]);
    endtask

    task automatic restart;
        soft_rst = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int cnt;
        logic [15:0] lfsr;
        bit first = 1'b1;
        repeat (3) @(negedge clk);
        chk(drdy_n === 1'b0, "R1 drdy_n in reset", longint'(drdy_n), 0);
        chk(data_out === '0, "R1 data_out in reset", longint'(data_out), 0);
        chk(from_fast === 1'b0, "R1 from_fast in reset", longint'(from_fast), 0);
        rst_n = 1'b1;
        cnt = 0;
        while (drdy_n !== 1'b1 && cnt < 1000) begin
            soft_rst = (cnt == 5);
            @(negedge clk);
            cnt++;
        end
        soft_rst = 1'b0;
        chk(cnt == PORC, "R2 power-on interval", cnt, PORC);

        // steady densities: every ones-count per period
        for (int k = 0; k <= OSR; k++) begin
            for (int n = 0; n < NX; n++) xb[n] = ((n % OSR) < k);
            if (!first) restart();
            first = 1'b0;
            run_seq(k[0], 1'b1);
            got_dc: begin
                logic [OW-1:0] w;
                w = data_out;
                chk(longint'($signed(w)) == longint'(2 * k - OSR) * (64'sd1 <<< (OW - 2 - LG)),
                    "R9 steady word after switch", longint'($signed(w)),
                    longint'(2 * k - OSR) * (64'sd1 <<< (OW - 2 - LG)));
            end
        end
        // density changing each period
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < NX; n++) xb[n] = ((n % OSR) < ((r * 5 + 4 * (n / OSR)) % (OSR + 1)));
            restart();
            run_seq(r[0], 1'b0);
        end
        // pseudo-random streams
        lfsr = 16'hACE1;
        for (int s = 0; s < 6; s++) begin
            for (int n = 0; n < NX; n++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                xb[n] = lfsr[0];
            end
            restart();
            run_seq(~s[0], 1'b0);
        end
        report();
    end
endmodule